// File: doc/BRIEF.md
# Host Inbound Error Filter

This block stands between the host-bus receive path and the device core. It sorts every inbound transaction into one of three outcomes. A transaction is forwarded to the core, or it is answered locally with a retry completion, or it is dropped in a single cycle. Configuration requests that arrive before the device has finished loading its non-volatile setup are not passed on. Instead, the block answers each of them with a retry completion that echoes the requester ID and tag.

Transactions that carry a parity flag are discarded, and the event is recorded in a sticky status bit. Completions are matched against a table of outstanding read tags. The core fills this table when it issues reads. A completion with a failing status is discarded and its tag is freed without any retry. A completion whose tag is not outstanding is discarded and counted. A one-cycle system-error pulse goes to the host whenever the enable inputs permit it.

Top module: `hef_inbound_filter`

## Requirements
- R1: Transaction kind encoding: 0 = memory read, 1 = memory write, 2 = configuration request, 3 = completion. While `init_done` is low, a configuration request without a parity flag is never forwarded. It raises `rsp_valid` in the same cycle, with `rsp_rid`/`rsp_tag` equal to the request's ID and tag and `rsp_status` = 3'b010.
- R2: A configuration request with `init_done` high, and any read or write request without a parity flag, is forwarded unchanged on the `fwd_*` port. `rsp_valid` stays low.
- R3: A transaction with `in_perr` high is never forwarded or answered. It is consumed with `in_ready` high. Its only effect is that `sts_perr` reads 1 from the cycle after acceptance. In particular, a parity-flagged completion leaves its tag outstanding.
- R4: An accepted parity-flagged transaction with `perr_en` high pulses `serr_pulse` for exactly the cycle after acceptance and sets `sts_serr`. With `perr_en` low it produces no pulse.
- R5: A completion to an outstanding tag with a `in_status` other than 3'b000 is dropped. Its bit in `tag_pending` clears and `sts_serr` sets whatever the enables are. `serr_pulse` fires for one cycle only when `serr_en` is high.
- R6: A completion with status 3'b000 to an outstanding tag is forwarded, and that tag's bit in `tag_pending` clears after the handshake.
- R7: A completion whose tag bit in `tag_pending` is 0 is dropped and consumed in one cycle. It increments `unexp_cnt`, which saturates at its all-ones value.
- R8: The sticky bits clear only on a `clr_perr`/`clr_serr` pulse. A new event in the same cycle as a clear leaves the bit set.
- R9: `in_ready` equals `fwd_ready` for a forwarded transaction and `rsp_ready` for a retry answer, and is 1 for any dropped transaction.
- R10: A `tag_alloc` pulse sets bit `tag_alloc_id` of `tag_pending` from the next cycle.
- R11: After reset, `sts_perr`, `sts_serr`, `serr_pulse`, `unexp_cnt` and `tag_pending` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Inbound transaction valid |
| in_ready | output | 1 | Inbound transaction accepted |
| in_kind | input | 2 | Transaction kind (R1 encoding) |
| in_perr | input | 1 | Parity error flag |
| in_status | input | 3 | Completion status |
| in_tag | input | TAG_W | Transaction tag |
| in_rid | input | RID_W | Requester ID |
| in_data | input | DATA_W | Payload |
| fwd_valid | output | 1 | Forward to core valid |
| fwd_ready | input | 1 | Core ready |
| fwd_kind | output | 2 | Forwarded kind |
| fwd_tag | output | TAG_W | Forwarded tag |
| fwd_rid | output | RID_W | Forwarded requester ID |
| fwd_data | output | DATA_W | Forwarded payload |
| rsp_valid | output | 1 | Retry completion valid |
| rsp_ready | input | 1 | Retry completion accepted |
| rsp_rid | output | RID_W | Echoed requester ID |
| rsp_tag | output | TAG_W | Echoed tag |
| rsp_status | output | 3 | Retry status code |
| init_done | input | 1 | Non-volatile setup complete |
| perr_en | input | 1 | Parity error reporting enable |
| serr_en | input | 1 | System error reporting enable |
| clr_perr | input | 1 | Clear parity status |
| clr_serr | input | 1 | Clear system error status |
| tag_alloc | input | 1 | Core issued a read |
| tag_alloc_id | input | TAG_W | Tag of the issued read |
| tag_pending | output | 2**TAG_W | Outstanding tag map |
| sts_perr | output | 1 | Sticky parity status |
| sts_serr | output | 1 | Sticky system error status |
| serr_pulse | output | 1 | System error indication |
| unexp_cnt | output | CNT_W | Unexpected completion count |

## Verification
The hardest state to reach is saturation of the unexpected-completion counter, because it needs hundreds of completions to tags that are not outstanding. The stimulus reaches it by holding one such completion valid for more than 255 cycles, since each cycle is consumed as a fresh drop. A second hard case is a parity-flagged completion to a live tag. From the ports it looks like a normal completion, and only the untouched bit in `tag_pending` shows that it was ignored. The stimulus first allocates the tag and later reads the map.

// File: rtl/hef_pkg.sv
package hef_pkg;
   typedef enum logic [1:0] {
      K_MRD = 2'd0,
      K_MWR = 2'd1,
      K_CFG = 2'd2,
      K_CPL = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      ACT_FWD  = 2'd0,
      ACT_RSP  = 2'd1,
      ACT_DROP = 2'd2
   } act_e;

   localparam logic [2:0] ST_SUCCESS = 3'b000;
   localparam logic [2:0] ST_RETRY   = 3'b010;
endpackage

// File: rtl/hef_classify.sv
module hef_classify
   import hef_pkg::*;
(
   input  logic [1:0] kind,
   input  logic       perr,
   input  logic [2:0] status,
   input  logic       tag_hit,
   input  logic       init_done,
   output act_e       act,
   output logic       f_unexp,
   output logic       f_bad,
   output logic       f_rel
);
   logic is_cpl;
   assign is_cpl  = (kind == K_CPL) && !perr;
   assign f_unexp = is_cpl && !tag_hit;
   assign f_bad   = is_cpl && tag_hit && (status != ST_SUCCESS);
   assign f_rel   = is_cpl && tag_hit;

   always_comb begin
      if (perr)                              act = ACT_DROP;
      else if (kind == K_CFG && !init_done)  act = ACT_RSP;
      else if (kind == K_CPL)                act = (tag_hit && status == ST_SUCCESS) ? ACT_FWD : ACT_DROP;
      else                                   act = ACT_FWD;
   end
endmodule

// File: rtl/hef_tag_tracker.sv
module hef_tag_tracker #(
   parameter int TAG_W = 4,
   localparam int NTAGS = 1 << TAG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc,
   input  logic [TAG_W-1:0] alloc_tag,
   input  logic             rel,
   input  logic [TAG_W-1:0] rel_tag,
   input  logic [TAG_W-1:0] lookup_tag,
   output logic             hit,
   output logic [NTAGS-1:0] pend
);
   for (genvar g = 0; g < NTAGS; g++) begin : g_tag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                     pend[g] <= 1'b0;
         else if (alloc && alloc_tag == TAG_W'(g))       pend[g] <= 1'b1;
         else if (rel && rel_tag == TAG_W'(g))           pend[g] <= 1'b0;
      end
   end

   assign hit = pend[lookup_tag];

   AST_TAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |=> pend[$past(alloc_tag)]); // R10
   AST_TAG_FREED: assert property (@(posedge clk) disable iff (!rst_n)
      (rel && !(alloc && alloc_tag == rel_tag)) |=> !pend[$past(rel_tag)]); // R5
endmodule

// File: rtl/hef_status.sv
module hef_status #(
   parameter int CNT_W     = 8,
   parameter bit UNEXP_SAT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_perr,
   input  logic             ev_bad,
   input  logic             ev_unexp,
   input  logic             perr_en,
   input  logic             serr_en,
   input  logic             clr_perr,
   input  logic             clr_serr,
   output logic             sts_perr,
   output logic             sts_serr,
   output logic             serr_pulse,
   output logic [CNT_W-1:0] unexp_cnt
);
   logic serr_set;
   assign serr_set = ev_bad || (ev_perr && perr_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_perr   <= 1'b0;
         sts_serr   <= 1'b0;
         serr_pulse <= 1'b0;
      end else begin
         if (ev_perr)        sts_perr <= 1'b1;
         else if (clr_perr)  sts_perr <= 1'b0;
         if (serr_set)       sts_serr <= 1'b1;
         else if (clr_serr)  sts_serr <= 1'b0;
         serr_pulse <= (ev_bad && serr_en) || (ev_perr && perr_en);
      end
   end

   if (UNEXP_SAT) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              unexp_cnt <= '0;
         else if (ev_unexp && unexp_cnt != '1)    unexp_cnt <= unexp_cnt + CNT_W'(1);
      end
      AST_UNEXP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> unexp_cnt >= $past(unexp_cnt)); // R7
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         unexp_cnt <= '0;
         else if (ev_unexp)  unexp_cnt <= unexp_cnt + CNT_W'(1);
      end
   end

   AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ev_perr |=> sts_perr); // R3
   AST_PERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_perr && !clr_perr) |=> sts_perr); // R8
   AST_SERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_serr && !clr_serr) |=> sts_serr); // R8
   AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      serr_pulse |-> ($past(perr_en) || $past(serr_en))); // R4
endmodule

// File: rtl/hef_inbound_filter.sv
module hef_inbound_filter
   import hef_pkg::*;
#(
   parameter int TAG_W     = 4,
   parameter int RID_W     = 16,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 8,
   parameter bit UNEXP_SAT = 1'b1,
   localparam int NTAGS    = 1 << TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_kind,
   input  logic              in_perr,
   input  logic [2:0]        in_status,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [RID_W-1:0]  in_rid,
   input  logic [DATA_W-1:0] in_data,
   output logic              fwd_valid,
   input  logic              fwd_ready,
   output logic [1:0]        fwd_kind,
   output logic [TAG_W-1:0]  fwd_tag,
   output logic [RID_W-1:0]  fwd_rid,
   output logic [DATA_W-1:0] fwd_data,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [RID_W-1:0]  rsp_rid,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [2:0]        rsp_status,
   input  logic              init_done,
   input  logic              perr_en,
   input  logic              serr_en,
   input  logic              clr_perr,
   input  logic              clr_serr,
   input  logic              tag_alloc,
   input  logic [TAG_W-1:0]  tag_alloc_id,
   output logic [NTAGS-1:0]  tag_pending,
   output logic              sts_perr,
   output logic              sts_serr,
   output logic              serr_pulse,
   output logic [CNT_W-1:0]  unexp_cnt
);
   if (TAG_W < 1 || TAG_W > 8) begin : g_bad_tag_w
      $error("hef_inbound_filter: TAG_W must be within 1..8");
   end
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("hef_inbound_filter: CNT_W must be at least 2");
   end

   act_e act;
   logic tag_hit, f_unexp, f_bad, f_rel, accept;

   hef_classify u_cls (
      .kind      (in_kind),
      .perr      (in_perr),
      .status    (in_status),
      .tag_hit   (tag_hit),
      .init_done (init_done),
      .act       (act),
      .f_unexp   (f_unexp),
      .f_bad     (f_bad),
      .f_rel     (f_rel)
   );

   always_comb begin
      case (act)
         ACT_FWD: in_ready = fwd_ready;
         ACT_RSP: in_ready = rsp_ready;
         default: in_ready = 1'b1;
      endcase
   end

   assign accept     = in_valid && in_ready;
   assign fwd_valid  = in_valid && (act == ACT_FWD);
   assign fwd_kind   = in_kind;
   assign fwd_tag    = in_tag;
   assign fwd_rid    = in_rid;
   assign fwd_data   = in_data;
   assign rsp_valid  = in_valid && (act == ACT_RSP);
   assign rsp_rid    = in_rid;
   assign rsp_tag    = in_tag;
   assign rsp_status = ST_RETRY;

   hef_tag_tracker #(.TAG_W(TAG_W)) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (tag_alloc),
      .alloc_tag  (tag_alloc_id),
      .rel        (accept && f_rel),
      .rel_tag    (in_tag),
      .lookup_tag (in_tag),
      .hit        (tag_hit),
      .pend       (tag_pending)
   );

   hef_status #(.CNT_W(CNT_W), .UNEXP_SAT(UNEXP_SAT)) u_sts (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_perr    (accept && in_perr),
      .ev_bad     (accept && f_bad),
      .ev_unexp   (accept && f_unexp),
      .perr_en    (perr_en),
      .serr_en    (serr_en),
      .clr_perr   (clr_perr),
      .clr_serr   (clr_serr),
      .sts_perr   (sts_perr),
      .sts_serr   (sts_serr),
      .serr_pulse (serr_pulse),
      .unexp_cnt  (unexp_cnt)
   );

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && fwd_kind == K_CFG) |-> init_done); // R1
   AST_RSP_PRE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (!init_done && in_kind == K_CFG)); // R1
   AST_NO_PERR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid || rsp_valid) |-> !in_perr); // R3
   AST_BAD_CPL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && f_bad) |=> sts_serr); // R5
   AST_OK_CPL_FREED: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && fwd_ready && in_kind == K_CPL && !(tag_alloc && tag_alloc_id == in_tag))
      |=> !tag_pending[$past(in_tag)]); // R6
endmodule

// File: tb/hef_inbound_filter_tb.sv
module hef_inbound_filter_tb;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n;
   logic        in_valid, in_ready, in_perr;
   logic [1:0]  in_kind;
   logic [2:0]  in_status;
   logic [3:0]  in_tag;
   logic [15:0] in_rid;
   logic [31:0] in_data;
   logic        fwd_valid, fwd_ready;
   logic [1:0]  fwd_kind;
   logic [3:0]  fwd_tag;
   logic [15:0] fwd_rid;
   logic [31:0] fwd_data;
   logic        rsp_valid, rsp_ready;
   logic [15:0] rsp_rid;
   logic [3:0]  rsp_tag;
   logic [2:0]  rsp_status;
   logic        init_done, perr_en, serr_en, clr_perr, clr_serr;
   logic        tag_alloc;
   logic [3:0]  tag_alloc_id;
   logic [15:0] tag_pending;
   logic        sts_perr, sts_serr, serr_pulse;
   logic [7:0]  unexp_cnt;

   hef_inbound_filter u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_perr(in_perr),
      .in_status(in_status), .in_tag(in_tag), .in_rid(in_rid), .in_data(in_data),
      .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_kind(fwd_kind), .fwd_tag(fwd_tag),
      .fwd_rid(fwd_rid), .fwd_data(fwd_data),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rid(rsp_rid), .rsp_tag(rsp_tag),
      .rsp_status(rsp_status),
      .init_done(init_done), .perr_en(perr_en), .serr_en(serr_en),
      .clr_perr(clr_perr), .clr_serr(clr_serr),
      .tag_alloc(tag_alloc), .tag_alloc_id(tag_alloc_id), .tag_pending(tag_pending),
      .sts_perr(sts_perr), .sts_serr(sts_serr), .serr_pulse(serr_pulse), .unexp_cnt(unexp_cnt)
   );

   typedef struct packed {
      logic [1:0] kind;
      logic       perr;
      logic [2:0] st;
      logic [3:0] tag;
      logic       init;
      logic       pen;
      logic       sen;
      logic       alloc;
      logic       efwd;
      logic       ersp;
      logic       epulse;
   } tv_t;

   localparam int NV = 10;
   localparam tv_t VEC [NV] = '{
      '{2'd2, 1'b0, 3'd0, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R1 cfg before init
      '{2'd2, 1'b0, 3'd0, 4'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 cfg after init
      '{2'd1, 1'b1, 3'd0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 perr reported
      '{2'd0, 1'b1, 3'd0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 perr silent
      '{2'd3, 1'b0, 3'd0, 4'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R6 good cpl
      '{2'd3, 1'b0, 3'd4, 4'd7, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R5 bad cpl, reported
      '{2'd3, 1'b0, 3'd1, 4'd9, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 bad cpl, silent
      '{2'd3, 1'b0, 3'd0, 4'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R7 unknown tag
      '{2'd3, 1'b1, 3'd0, 4'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 perr cpl
      '{2'd1, 1'b0, 3'd0, 4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}   // R2 write
   };

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_kind = 2'd0; in_perr = 1'b0; in_status = 3'd0;
      in_tag = 4'd0; in_rid = 16'h0; in_data = 32'h0; fwd_ready = 1'b1; rsp_ready = 1'b1;
      init_done = 1'b0; perr_en = 1'b0; serr_en = 1'b0; clr_perr = 1'b0; clr_serr = 1'b0;
      tag_alloc = 1'b0; tag_alloc_id = 4'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R11 reset state
      chk("R11", {31'd0, sts_perr}, 32'd0);
      chk("R11", {31'd0, sts_serr}, 32'd0);
      chk("R11", {31'd0, serr_pulse}, 32'd0);
      chk("R11", {24'd0, unexp_cnt}, 32'd0);
      chk("R11", {16'd0, tag_pending}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         tv_t v;
         string rq;
         v = VEC[i];
         rq = $sformatf("vec%0d R1..", i);
         rq = v.ersp ? "R1" : (v.kind == 2'd3 && !v.perr) ? (v.efwd ? "R6" : (v.st != 0 ? "R5" : "R7"))
              : v.perr ? "R4" : "R2";
         if (v.alloc) begin
            tag_alloc = 1'b1; tag_alloc_id = v.tag;
            step();
            tag_alloc = 1'b0;
            chk("R10", {31'd0, tag_pending[v.tag]}, 32'd1);
         end
         in_kind = v.kind; in_perr = v.perr; in_status = v.st; in_tag = v.tag;
         in_rid = 16'hA5C3 + 16'(i); in_data = 32'h1000 + i;
         init_done = v.init; perr_en = v.pen; serr_en = v.sen;
         in_valid = 1'b1;
         #1;
         chk(rq, {31'd0, fwd_valid}, {31'd0, v.efwd});
         chk(rq, {31'd0, rsp_valid}, {31'd0, v.ersp});
         chk("R9", {31'd0, in_ready}, 32'd1);
         if (v.ersp) begin
            chk("R1", {16'd0, rsp_rid}, {16'd0, 16'hA5C3 + 16'(i)});
            chk("R1", {28'd0, rsp_tag}, {28'd0, v.tag});
            chk("R1", {29'd0, rsp_status}, 32'd2);
         end
         if (v.efwd) chk("R2", fwd_data, 32'h1000 + i);
         step();
         in_valid = 1'b0;
         chk(v.perr ? "R4" : "R5", {31'd0, serr_pulse}, {31'd0, v.epulse});
      end

      step();
      chk("R4", {31'd0, serr_pulse}, 32'd0);
      // R3 perr cpl left tag 2 outstanding; R5/R6 freed 5, 7, 9
      chk("R3", {16'd0, tag_pending}, 32'h0004);
      chk("R7", {24'd0, unexp_cnt}, 32'd1);
      chk("R3", {31'd0, sts_perr}, 32'd1);
      chk("R5", {31'd0, sts_serr}, 32'd1);

      // R8 clear only by pulse, one bit at a time
      perr_en = 1'b0; serr_en = 1'b0;
      repeat (3) step();
      chk("R8", {31'd0, sts_perr}, 32'd1);
      clr_perr = 1'b1; step(); clr_perr = 1'b0;
      chk("R8", {31'd0, sts_perr}, 32'd0);
      chk("R8", {31'd0, sts_serr}, 32'd1);
      clr_serr = 1'b1; step(); clr_serr = 1'b0;
      chk("R8", {31'd0, sts_serr}, 32'd0);

      // R8 event beats clear in the same cycle
      in_kind = 2'd1; in_perr = 1'b1; clr_perr = 1'b1; in_valid = 1'b1;
      step();
      in_valid = 1'b0; clr_perr = 1'b0; in_perr = 1'b0;
      chk("R8", {31'd0, sts_perr}, 32'd1);

      // R5 bad completion with both enables off: sticky set, no pulse
      tag_alloc = 1'b1; tag_alloc_id = 4'd11; step(); tag_alloc = 1'b0;
      in_kind = 2'd3; in_tag = 4'd11; in_status = 3'd7; in_valid = 1'b1;
      step();
      in_valid = 1'b0;
      chk("R5", {31'd0, sts_serr}, 32'd1);
      chk("R5", {31'd0, serr_pulse}, 32'd0);
      chk("R5", {31'd0, tag_pending[11]}, 32'd0);

      // R9 backpressure
      fwd_ready = 1'b0; rsp_ready = 1'b0;
      in_kind = 2'd1; in_perr = 1'b0; in_valid = 1'b1; #1;
      chk("R9", {31'd0, in_ready}, 32'd0);
      step();
      in_kind = 2'd2; init_done = 1'b0; fwd_ready = 1'b1; #1;
      chk("R9", {31'd0, in_ready}, 32'd0);
      rsp_ready = 1'b1; #0.5;
      chk("R9", {31'd0, in_ready}, 32'd1);
      step();
      fwd_ready = 1'b0; rsp_ready = 1'b0;
      in_kind = 2'd3; in_tag = 4'd13; in_status = 3'd0; #1;
      chk("R9", {31'd0, in_ready}, 32'd1);
      step();
      in_valid = 1'b0;
      chk("R7", {24'd0, unexp_cnt}, 32'd2);

      // R7 saturation of the unexpected counter
      in_valid = 1'b1;
      repeat (260) step();
      in_valid = 1'b0;
      step();
      chk("R7", {24'd0, unexp_cnt}, 32'd255);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule